// File: doc/BRIEF.md
# Four-Channel DMA Request and Bus Hold Controller

This block is the request half of a four-channel DMA controller. Each peripheral drives one request line. The block qualifies these lines with a per-channel mask and a global disable flag. When at least one qualified request remains, it raises a hold request to the host processor. When the host answers with hold acknowledge, the block takes ownership of the bus. It then latches a grant for the highest-priority qualified channel and presents that channel's address and transfer-type registers for the transfer engine downstream.

The host programs the block through a simple byte-wide write port. Writes take effect only while hold acknowledge is low, even if hold request is already raised. Each channel's 16-bit address is loaded as two byte writes, sequenced by a shared byte pointer. If a qualified request arrives between the two writes, the half-written address is served. The host prevents this by disabling the controller or masking the channel first.

Top module: `dma_req_hold`

## Requirements
- R1: After reset, hold request and every grant bit are 0, all four channels are masked, the controller is enabled, every transfer type is 00, every address register is 0 and the byte pointer selects the low byte.
- R2: Hold request is a registered value. One clock after at least one channel has its request high, is unmasked and the controller is enabled, it is 1. One clock after no such channel remains, it is 0.
- R3: A write to register 4 stores the command byte. Its bit 2 set to 1 disables the controller, which keeps hold request low and blocks new grants. Bit 2 set to 0 enables the controller.
- R4: When hold acknowledge is high, hold request is high and no grant is held, the next clock latches a one-hot grant for the lowest-numbered qualified channel (channel 0 has the highest priority). The grant is held while hold acknowledge stays high.
- R5: The grant is all zero one clock after hold acknowledge is low. The bus-ownership output is 1 exactly when a grant bit is set.
- R6: A masked channel never raises hold request and is never granted. Register 5 updates one mask bit: data[1:0] selects the channel and data[2] is the new mask value (1 masks). Register 8 writes all four mask bits from data[3:0].
- R7: Every host write is ignored while hold acknowledge is high.
- R8: A write to registers 0 to 3 loads a byte of that channel's address. The low byte is loaded when the byte pointer is 0 and the high byte when it is 1. The pointer toggles on each such write. A write to register 7 clears the pointer. The granted channel's address appears on the service address output, even if it is half-written.
- R9: A write to register 6 sets a transfer type. data[1:0] selects the channel and data[3:2] gives the type. The type value 11 is invalid and is ignored. The granted channel's type appears on the service mode output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dreq | input | 4 | Per-channel peripheral request |
| hlda | input | 1 | Hold acknowledge from host |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 4 | Host register select |
| wr_data | input | 8 | Host write data |
| hrq | output | 1 | Hold request to host |
| bus_own | output | 1 | Block owns the bus |
| grant | output | 4 | One-hot granted channel |
| svc_addr | output | 16 | Address register of granted channel |
| svc_mode | output | 2 | Transfer type of granted channel |

## Verification
On every clock, the assertions check the following. Hold request follows the qualified requests with one cycle of latency in both directions. The grant is one-hot and is cleared when hold acknowledge falls. No masked channel holds a grant. The mask and disable state do not change while the host has given up the bus. Only the bench's scenarios can show the rest: which channel wins when several request at once, how the byte pointer sequences, what the clear command does, that an invalid transfer type is rejected, and that a half-written address is served on the service outputs.

// File: rtl/dma_req_hold.sv
module dma_req_hold #(
  parameter int NCH = 4,
  parameter int AW  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   dreq,
  input  logic             hlda,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output logic             hrq,
  output logic             bus_own,
  output logic [NCH-1:0]   grant,
  output logic [AW-1:0]    svc_addr,
  output logic [1:0]       svc_mode
);
  localparam int CW = $clog2(NCH);
  localparam logic [3:0] RG_CMD   = 4'd4;
  localparam logic [3:0] RG_MSK1  = 4'd5;
  localparam logic [3:0] RG_MODE  = 4'd6;
  localparam logic [3:0] RG_CLRP  = 4'd7;
  localparam logic [3:0] RG_MSKA  = 4'd8;

  logic [NCH-1:0] mask_q;
  logic           dis_q;
  logic           ptr_q;
  logic           hrq_q;
  logic [NCH-1:0] grant_q;
  logic [AW-1:0]  addr_q [NCH];
  logic [1:0]     mode_q [NCH];
  logic [NCH-1:0] valid, pick;

  wire wr_ok = wr_en & ~hlda;
  wire [CW-1:0] sel_ch = wr_data[CW-1:0];

  assign valid   = dreq & ~mask_q & {NCH{~dis_q}};
  assign hrq     = hrq_q;
  assign grant   = grant_q;
  assign bus_own = |grant_q;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (valid[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
  end

  always_comb begin
    svc_addr = '0;
    svc_mode = '0;
    for (int i = 0; i < NCH; i++)
      if (grant_q[i]) begin
        svc_addr = addr_q[i];
        svc_mode = mode_q[i];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hrq_q   <= 1'b0;
      grant_q <= '0;
    end else begin
      hrq_q <= |valid;
      if (!hlda)
        grant_q <= '0;
      else if (grant_q == '0 && hrq_q)
        grant_q <= pick;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      dis_q  <= 1'b0;
      ptr_q  <= 1'b0;
    end else if (wr_ok) begin
      if (wr_addr < 4'(NCH))
        ptr_q <= ~ptr_q;
      case (wr_addr)
        RG_CMD:  dis_q  <= wr_data[2];
        RG_MSK1: mask_q[sel_ch] <= wr_data[2];
        RG_CLRP: ptr_q  <= 1'b0;
        RG_MSKA: mask_q <= wr_data[NCH-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_q[g] <= '0;
        mode_q[g] <= 2'b00;
      end else if (wr_ok) begin
        if (wr_addr == 4'(g)) begin
          if (ptr_q) addr_q[g][AW-1:8] <= wr_data[AW-9:0];
          else       addr_q[g][7:0]    <= wr_data;
        end
        if (wr_addr == RG_MODE && sel_ch == CW'(g) && wr_data[3:2] != 2'b11)
          mode_q[g] <= wr_data[3:2];
      end
    end
  end
endmodule

// File: rtl/dma_req_hold_chk.sv
module dma_req_hold_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] dreq,
  input logic           hlda,
  input logic           hrq,
  input logic [NCH-1:0] grant,
  input logic [NCH-1:0] mask_q,
  input logic           dis_q
);
  wire any_q = !dis_q && |(dreq & ~mask_q);

  a_r2_hrq_rise: assert property (@(posedge clk) disable iff (!rst_n) any_q |=> hrq);
  a_r2_hrq_fall: assert property (@(posedge clk) disable iff (!rst_n) !any_q |=> !hrq);
  a_r4_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));
  a_r5_grant_release: assert property (@(posedge clk) disable iff (!rst_n) !hlda |=> grant == '0);
  a_r6_no_masked_grant: assert property (@(posedge clk) disable iff (!rst_n) (grant & mask_q) == '0);
  a_r7_frozen_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |=> ($stable(mask_q) && $stable(dis_q)));
endmodule

bind dma_req_hold dma_req_hold_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .dreq(dreq), .hlda(hlda), .hrq(hrq),
  .grant(grant), .mask_q(mask_q), .dis_q(dis_q)
);

// File: tb/dma_req_hold_tb.sv
`timescale 1ns/1ps
module dma_req_hold_tb;
  logic clk = 0, rst_n = 0, hlda = 0, wr_en = 0;
  logic [3:0] dreq = 0, wr_addr = 0, grant;
  logic [7:0] wr_data = 0;
  logic hrq, bus_own;
  logic [15:0] svc_addr;
  logic [1:0] svc_mode;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  dma_req_hold u_dut (.clk(clk), .rst_n(rst_n), .dreq(dreq), .hlda(hlda), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .hrq(hrq), .bus_own(bus_own), .grant(grant),
    .svc_addr(svc_addr), .svc_mode(svc_mode));

  // {disable, mask[3:0], dreq[3:0], expected hrq}
  localparam logic [9:0] VEC [8] = '{
    10'b0_0000_0000_0, 10'b0_0000_0001_1, 10'b0_0001_0001_0, 10'b0_1110_1111_1,
    10'b0_1111_1111_0, 10'b1_0000_1111_0, 10'b0_0101_1010_1, 10'b0_1010_1010_0
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic tick(); @(negedge clk); endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    // R1 reset state; all channels masked so a request is ignored
    dreq = 4'hF; tick(); tick();
    check("R1 hrq", hrq, 0);
    check("R1 grant", grant, 0);
    check("R1 bus_own", bus_own, 0);
    dreq = 0;

    // R2 R3 R6 vector table
    for (int i = 0; i < 8; i++) begin
      wr(4'd8, {4'b0, VEC[i][8:5]});
      wr(4'd4, {5'b0, VEC[i][9], 2'b0});
      dreq = VEC[i][4:1];
      tick();
      check("R2/R3/R6 hrq vector", hrq, VEC[i][0]);
    end
    dreq = 0; tick();
    check("R2 hrq falls", hrq, 0);

    // R4 priority and R7 write ignore
    wr(4'd4, 8'h00); wr(4'd8, 8'h00);
    dreq = 4'b1010; tick();
    check("R2 hrq rises", hrq, 1);
    hlda = 1; tick();
    check("R4 lowest channel wins", grant, 4'b0010);
    check("R5 bus_own", bus_own, 1);
    check("R1 default mode", svc_mode, 0);
    dreq = 4'b1011; tick();
    check("R4 grant held", grant, 4'b0010);
    wr(4'd8, 8'h0F); wr(4'd4, 8'h04); tick();
    check("R7 mask/disable writes ignored", hrq, 1);
    hlda = 0; tick();
    check("R5 grant cleared", grant, 0);
    check("R5 bus_own low", bus_own, 0);
    hlda = 1; tick();
    check("R4 ch0 highest", grant, 4'b0001);
    hlda = 0; dreq = 0; tick();

    // R3 disable blocks
    wr(4'd4, 8'h04); dreq = 4'b0010; tick();
    check("R3 disabled hrq", hrq, 0);
    hlda = 1; tick();
    check("R3 no grant disabled", grant, 0);
    hlda = 0; wr(4'd4, 8'h00); tick();
    check("R3 reenabled hrq", hrq, 1);
    dreq = 0;

    // R6 single mask
    wr(4'd5, 8'h05); dreq = 4'b0010; tick();
    check("R6 single mask sets ch1", hrq, 0);
    wr(4'd5, 8'h01); tick();
    check("R6 single mask clears ch1", hrq, 1);
    dreq = 0;

    // R8 R9 address and mode
    wr(4'd7, 8'h00); wr(4'd1, 8'h34); wr(4'd1, 8'h12);
    wr(4'd6, 8'h09); wr(4'd6, 8'h0D);
    dreq = 4'b0010; tick(); hlda = 1; tick();
    check("R8 full address", svc_addr, 16'h1234);
    check("R9 mode kept, 11 rejected", svc_mode, 2);
    wr(4'd1, 8'h77); tick();
    check("R7 address write ignored", svc_addr, 16'h1234);
    hlda = 0; dreq = 0; tick();
    wr(4'd1, 8'hCD);
    dreq = 4'b0010; tick(); hlda = 1; tick();
    check("R8 half-written address served", svc_addr, 16'h12CD);
    hlda = 0; dreq = 0; tick();
    wr(4'd7, 8'h00); wr(4'd1, 8'hEF);
    dreq = 4'b0010; tick(); hlda = 1; tick();
    check("R8 pointer clear selects low byte", svc_addr, 16'h12EF);
    hlda = 0; dreq = 0; tick();

    // R1 reset restores masks and clears grant
    rst_n = 0; tick(); rst_n = 1; dreq = 4'b0001; tick(); tick();
    check("R1 masked after reset", hrq, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule